// File: doc/BRIEF.md
# Data Access Translation Checker

This unit decides, for one data access at a time, where a virtual address lands in the physical space and whether the access may proceed. A request carries a 32-bit virtual address, a read/write flag, the current privilege level, the current address-space identifier and three control bits: a translation enable, an ASID-bypass bit for privileged code, and a lock that keeps user code out of the store-queue window. Fixed high regions are mapped without a table walk. Every other address is matched against a set of translation entries driven into the block on a flat bus.

The block returns either a physical address or exactly one exception code. Both are registered and presented together with a one-cycle valid strobe. The TLB contents, exception vectoring and any cache side effects belong to the surrounding logic.

Top module: `dat_xlate_check`

## Requirements
- R1: In privileged mode an address at or above 0xE0000000 is returned unchanged with code 0 (none). A privileged access never yields code 1 (address error).
- R2: In privileged mode an address from 0x80000000 to 0xBFFFFFFF is returned with bits 31:29 cleared and code 0.
- R3: In user mode an address with bit 31 set yields code 1, except for addresses 0xE0000000 to 0xE3FFFFFF while the store-queue lock input is 0, which are returned unchanged with code 0.
- R4: With translation disabled, addresses below 0x80000000 and privileged addresses 0xC0000000 to 0xDFFFFFFF are returned with bits 31:29 cleared. With translation enabled, both ranges go through the TLB.
- R5: Entry i occupies bits [56*i+55 : 56*i] of the TLB bus, packed from the top as {vpn[21:0], asid[7:0], ppn[18:0], size[1:0], valid, shared, user, writable, dirty}. Size 0, 1, 2 and 3 selects 1 KB, 4 KB, 64 KB and 1 MB pages. An entry matches when it is valid, its VPN equals address bits 31:10 above the page offset, and it is shared, or its ASID equals the current ASID, or the ASID-bypass bit is 1 in privileged mode.
- R6: When no entry matches, the code is 2 for a read and 3 for a write. When two or more entries match, the code is 4.
- R7: A user-mode read of an entry whose user bit is 0 yields code 5. Privileged reads are never refused by protection.
- R8: A privileged write needs the writable bit. A user write needs both the user bit and the writable bit. A failed check yields code 6.
- R9: A write that passes protection to an entry whose dirty bit is 0 yields code 7.
- R10: A translated physical address takes its page-number bits from the PPN and its page-offset bits from the virtual address, as set by the page size. Bits 31:29 are zero.
- R11: Codes follow the priority address error, then miss, then multi-hit, then protection, then initial write. Only one code is reported per access.
- R12: After reset, valid, code and address are 0. valid_o is 1 exactly in the cycle after req_i is sampled. The address is 0 whenever the code is not 0. Code and address hold while no request arrives.

Port descriptions for the top module, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one access per cycle |
| vaddr_i | input | 32 | Virtual address |
| write_i | input | 1 | 1 for a write, 0 for a read |
| priv_i | input | 1 | 1 for privileged mode |
| xlate_en_i | input | 1 | Enables address translation |
| asid_bypass_i | input | 1 | Privileged lookups ignore the ASID |
| sq_user_lock_i | input | 1 | Blocks user access to the store-queue window |
| asid_i | input | 8 | Current address-space identifier |
| tlb_entries_i | input | 56*NUM_ENT | Flat TLB entry bus, layout in R5 |
| valid_o | output | 1 | Result strobe |
| pa_o | output | 32 | Physical address |
| exc_o | output | 3 | Exception code, 0 when the access is allowed |

## Verification
The temporal checks assume that the TLB bus and the control inputs are stable from the request edge until the result edge. They also assume that req_i is a clean level sampled once per cycle. The stimulus keeps within these limits: it drives every input, including entry rewrites for the multi-hit and priority cases, at the falling edge before it raises the request, and changes nothing until the result has been read. The rule that the address reads 0 on every exception holds whatever the entry contents are, so overlapping or invalid entries are legal stimulus.

// File: rtl/dxc_pkg.sv
`timescale 1ns/1ps
package dxc_pkg;
  localparam int VA_W   = 32;
  localparam int PG_LSB = 10;
  localparam int VPN_W  = VA_W - PG_LSB;
  localparam int PA_W   = 29;
  localparam int PPN_W  = PA_W - PG_LSB;
  localparam int ASID_W = 8;

  localparam logic [VA_W-1:0] P3_BASE  = 32'hC000_0000;
  localparam logic [VA_W-1:0] P4_BASE  = 32'hE000_0000;
  localparam logic [VA_W-1:0] SQ_END   = 32'hE400_0000;
  localparam logic [VA_W-1:0] EXT_MASK = 32'h1FFF_FFFF;

  typedef enum logic [1:0] {PG_1K, PG_4K, PG_64K, PG_1M} pg_size_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    pg_size_e          size;
    logic              valid;
    logic              shared;
    logic              user_ok;
    logic              wr_ok;
    logic              dirty;
  } tlb_ent_t;

  localparam int ENT_W = $bits(tlb_ent_t);

  typedef enum logic [2:0] {
    EXC_NONE, EXC_ADDR, EXC_RD_MISS, EXC_WR_MISS,
    EXC_MULTI, EXC_RD_PROT, EXC_WR_PROT, EXC_INIT_WR
  } exc_e;

  typedef enum logic [1:0] {RG_RAW, RG_EXT, RG_ERR, RG_XLATE} region_e;

  // compare mask over VPN bits; cleared bits belong to the page offset
  function automatic logic [VPN_W-1:0] vpn_mask(pg_size_e s);
    logic [VPN_W-1:0] m;
    m = '1;
    case (s)
      PG_1K:   m = m;
      PG_4K:   m = m << 2;
      PG_64K:  m = m << 6;
      default: m = m << 10;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/dxc_region.sv
`timescale 1ns/1ps
module dxc_region
  import dxc_pkg::*;
(
  input  logic [VA_W-1:0] vaddr_i,
  input  logic            priv_i,
  input  logic            sq_lock_i,
  input  logic            xlate_en_i,
  output region_e         region_o
);
  logic in_sq;
  assign in_sq = (vaddr_i >= P4_BASE) && (vaddr_i < SQ_END);

  always_comb begin
    if (vaddr_i[VA_W-1]) begin
      if (priv_i) begin
        if (vaddr_i >= P4_BASE)      region_o = RG_RAW;
        else if (vaddr_i < P3_BASE)  region_o = RG_EXT;
        else                         region_o = xlate_en_i ? RG_XLATE : RG_EXT;
      end else begin
        region_o = (in_sq && !sq_lock_i) ? RG_RAW : RG_ERR;
      end
    end else begin
      region_o = xlate_en_i ? RG_XLATE : RG_EXT;
    end
  end
endmodule

// File: rtl/dxc_match.sv
`timescale 1ns/1ps
module dxc_match
  import dxc_pkg::*;
#(
  parameter int NUM_ENT = 4
) (
  input  logic [NUM_ENT*ENT_W-1:0] entries_i,
  input  logic [VPN_W-1:0]         vpn_i,
  input  logic [ASID_W-1:0]        asid_i,
  input  logic                     ign_asid_i,
  output logic [NUM_ENT-1:0]       hit_vec_o,
  output logic                     hit_any_o,
  output logic                     multi_o,
  output logic [PPN_W-1:0]         sel_ppn_o,
  output pg_size_e                 sel_size_o,
  output logic                     sel_user_o,
  output logic                     sel_wr_o,
  output logic                     sel_dirty_o
);
  tlb_ent_t ents [NUM_ENT];

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic [VPN_W-1:0] cmp_mask;
    logic             asid_ok;
    assign ents[i]      = tlb_ent_t'(entries_i[i*ENT_W +: ENT_W]);
    assign cmp_mask     = vpn_mask(ents[i].size);
    assign asid_ok      = ents[i].shared || ign_asid_i || (ents[i].asid == asid_i);
    assign hit_vec_o[i] = ents[i].valid && asid_ok &&
                          (((ents[i].vpn ^ vpn_i) & cmp_mask) == '0);
  end

  // OR-mux of hitting entries; content only meaningful on a single hit
  always_comb begin
    logic     seen;
    tlb_ent_t sel;
    seen    = 1'b0;
    multi_o = 1'b0;
    sel     = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (hit_vec_o[i]) begin
        if (seen) multi_o = 1'b1;
        seen = 1'b1;
        sel  = tlb_ent_t'(sel | ents[i]);
      end
    end
    hit_any_o   = seen;
    sel_ppn_o   = sel.ppn;
    sel_size_o  = sel.size;
    sel_user_o  = sel.user_ok;
    sel_wr_o    = sel.wr_ok;
    sel_dirty_o = sel.dirty;
  end
endmodule

// File: rtl/dxc_perm.sv
`timescale 1ns/1ps
module dxc_perm
  import dxc_pkg::*;
(
  input  logic [PA_W-1:0]  vaddr_i,
  input  logic             write_i,
  input  logic             priv_i,
  input  logic             hit_any_i,
  input  logic             multi_i,
  input  logic [PPN_W-1:0] ppn_i,
  input  pg_size_e         size_i,
  input  logic             user_i,
  input  logic             wr_i,
  input  logic             dirty_i,
  output exc_e             exc_o,
  output logic [VA_W-1:0]  pa_o
);
  logic [VPN_W-1:0] m;
  logic [PPN_W-1:0] pm;
  logic             wr_denied;

  assign m  = vpn_mask(size_i);
  assign pm = m[PPN_W-1:0];
  assign pa_o = {{(VA_W-PA_W){1'b0}},
                 (ppn_i & pm) | (vaddr_i[PA_W-1:PG_LSB] & ~pm),
                 vaddr_i[PG_LSB-1:0]};

  assign wr_denied = priv_i ? !wr_i : !(user_i && wr_i);

  always_comb begin
    if (!hit_any_i)                  exc_o = write_i ? EXC_WR_MISS : EXC_RD_MISS;
    else if (multi_i)                exc_o = EXC_MULTI;
    else if (write_i && wr_denied)   exc_o = EXC_WR_PROT;
    else if (write_i && !dirty_i)    exc_o = EXC_INIT_WR;
    else if (!write_i && !priv_i && !user_i) exc_o = EXC_RD_PROT;
    else                             exc_o = EXC_NONE;
  end
endmodule

// File: rtl/dat_xlate_check.sv
`timescale 1ns/1ps
module dat_xlate_check
  import dxc_pkg::*;
#(
  parameter int NUM_ENT = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic [31:0]              vaddr_i,
  input  logic                     write_i,
  input  logic                     priv_i,
  input  logic                     xlate_en_i,
  input  logic                     asid_bypass_i,
  input  logic                     sq_user_lock_i,
  input  logic [7:0]               asid_i,
  input  logic [NUM_ENT*56-1:0]    tlb_entries_i,
  output logic                     valid_o,
  output logic [31:0]              pa_o,
  output logic [2:0]               exc_o
);
  region_e          region;
  logic [NUM_ENT-1:0] hit_vec;
  logic             hit_any, multi;
  logic [PPN_W-1:0] sel_ppn;
  pg_size_e         sel_size;
  logic             sel_user, sel_wr, sel_dirty;
  exc_e             tlb_exc, exc_d;
  logic [VA_W-1:0]  tlb_pa, pa_d;

  dxc_region u_region (
    .vaddr_i    (vaddr_i),
    .priv_i     (priv_i),
    .sq_lock_i  (sq_user_lock_i),
    .xlate_en_i (xlate_en_i),
    .region_o   (region)
  );

  dxc_match #(.NUM_ENT(NUM_ENT)) u_match (
    .entries_i   (tlb_entries_i),
    .vpn_i       (vaddr_i[VA_W-1:PG_LSB]),
    .asid_i      (asid_i),
    .ign_asid_i  (asid_bypass_i && priv_i),
    .hit_vec_o   (hit_vec),
    .hit_any_o   (hit_any),
    .multi_o     (multi),
    .sel_ppn_o   (sel_ppn),
    .sel_size_o  (sel_size),
    .sel_user_o  (sel_user),
    .sel_wr_o    (sel_wr),
    .sel_dirty_o (sel_dirty)
  );

  dxc_perm u_perm (
    .vaddr_i   (vaddr_i[PA_W-1:0]),
    .write_i   (write_i),
    .priv_i    (priv_i),
    .hit_any_i (hit_any),
    .multi_i   (multi),
    .ppn_i     (sel_ppn),
    .size_i    (sel_size),
    .user_i    (sel_user),
    .wr_i      (sel_wr),
    .dirty_i   (sel_dirty),
    .exc_o     (tlb_exc),
    .pa_o      (tlb_pa)
  );

  always_comb begin
    exc_d = EXC_NONE;
    pa_d  = '0;
    case (region)
      RG_RAW:  pa_d = vaddr_i;
      RG_EXT:  pa_d = vaddr_i & EXT_MASK;
      RG_ERR:  exc_d = EXC_ADDR;
      default: begin
        exc_d = tlb_exc;
        pa_d  = (tlb_exc == EXC_NONE) ? tlb_pa : '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pa_o    <= '0;
      exc_o   <= EXC_NONE;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        pa_o  <= pa_d;
        exc_o <= exc_d;
      end
    end
  end

  assert_valid_follows_req_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  assert_no_spurious_valid_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  assert_hold_when_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(pa_o) && $stable(exc_o)));
  assert_err_zero_pa_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && exc_o != EXC_NONE) |-> pa_o == '0);
  assert_xlate_off_no_tlb_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !xlate_en_i) |=> (exc_o == EXC_NONE || exc_o == EXC_ADDR));
  assert_priv_no_addr_err_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && priv_i) |=> (exc_o != EXC_ADDR && exc_o != EXC_RD_PROT));
  assert_read_no_write_code_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !write_i) |=> (exc_o != EXC_WR_MISS && exc_o != EXC_WR_PROT &&
                             exc_o != EXC_INIT_WR));
  assert_single_hit_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !multi |-> $onehot0(hit_vec));
endmodule

// File: tb/tb_dat_xlate_check.sv
`timescale 1ns/1ps
module tb_dat_xlate_check;
  localparam int NE = 4;
  localparam int NV = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [31:0] va = '0;
  logic wr = 1'b0, priv = 1'b0, at = 1'b0, sv = 1'b0, sqmd = 1'b0;
  logic [7:0] asid = '0;
  logic [NE*56-1:0] tlb;
  logic valid;
  logic [31:0] pa;
  logic [2:0] exc;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dat_xlate_check #(.NUM_ENT(NE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .vaddr_i(va), .write_i(wr),
    .priv_i(priv), .xlate_en_i(at), .asid_bypass_i(sv), .sq_user_lock_i(sqmd),
    .asid_i(asid), .tlb_entries_i(tlb), .valid_o(valid), .pa_o(pa), .exc_o(exc));

  function automatic logic [55:0] mk(logic [21:0] vpn, logic [7:0] as, logic [18:0] ppn,
                                     logic [1:0] sz, logic v, logic s, logic u,
                                     logic w, logic d);
    return {vpn, as, ppn, sz, v, s, u, w, d};
  endfunction

  // {req_no, vaddr, {wr,priv,at,sv,sqmd}, asid, exp_code, exp_pa}
  localparam logic [83:0] VEC [NV] = '{
    {4'd1,  32'hE0001234, 5'b01100, 8'h10, 3'd0, 32'hE0001234}, // R1
    {4'd1,  32'hFF000010, 5'b11100, 8'h10, 3'd0, 32'hFF000010}, // R1
    {4'd2,  32'h8C001000, 5'b01100, 8'h10, 3'd0, 32'h0C001000}, // R2
    {4'd2,  32'hA0000004, 5'b01100, 8'h10, 3'd0, 32'h00000004}, // R2
    {4'd3,  32'h80000000, 5'b00100, 8'h10, 3'd1, 32'h00000000}, // R3
    {4'd3,  32'hE2000040, 5'b00100, 8'h10, 3'd0, 32'hE2000040}, // R3
    {4'd3,  32'hE2000040, 5'b00101, 8'h10, 3'd1, 32'h00000000}, // R3
    {4'd3,  32'hE4000000, 5'b00100, 8'h10, 3'd1, 32'h00000000}, // R3
    {4'd4,  32'h60001234, 5'b00000, 8'h10, 3'd0, 32'h00001234}, // R4
    {4'd4,  32'hC0001000, 5'b01000, 8'h10, 3'd0, 32'h00001000}, // R4
    {4'd10, 32'h00400ABC, 5'b00100, 8'h10, 3'd0, 32'h0C000ABC}, // R10
    {4'd5,  32'h00400ABC, 5'b00100, 8'h11, 3'd2, 32'h00000000}, // R5
    {4'd6,  32'h00400ABC, 5'b10100, 8'h11, 3'd3, 32'h00000000}, // R6
    {4'd5,  32'h00400ABC, 5'b01110, 8'h11, 3'd0, 32'h0C000ABC}, // R5
    {4'd5,  32'h00400ABC, 5'b01100, 8'h11, 3'd2, 32'h00000000}, // R5
    {4'd10, 32'h010BCDEF, 5'b00100, 8'h77, 3'd0, 32'h0A0BCDEF}, // R10
    {4'd8,  32'h010BCDEF, 5'b10100, 8'h77, 3'd6, 32'h00000000}, // R8
    {4'd8,  32'h010BCDEF, 5'b11100, 8'h77, 3'd6, 32'h00000000}, // R8
    {4'd7,  32'h00800100, 5'b00100, 8'h22, 3'd5, 32'h00000000}, // R7
    {4'd7,  32'h00800100, 5'b01100, 8'h22, 3'd0, 32'h00100100}, // R7
    {4'd8,  32'h00800100, 5'b10100, 8'h22, 3'd6, 32'h00000000}, // R8
    {4'd8,  32'h00800100, 5'b11100, 8'h22, 3'd0, 32'h00100100}, // R8
    {4'd9,  32'h0200F00C, 5'b11100, 8'h10, 3'd7, 32'h00000000}, // R9
    {4'd10, 32'h0200F00C, 5'b01100, 8'h10, 3'd0, 32'h0500F00C}, // R10
    {4'd5,  32'h00800100, 5'b00100, 8'h10, 3'd2, 32'h00000000}, // R5
    {4'd4,  32'hC0000000, 5'b01100, 8'h10, 3'd2, 32'h00000000}, // R4
    {4'd9,  32'h0200F00C, 5'b10100, 8'h10, 3'd7, 32'h00000000}, // R9
    {4'd11, 32'hE2000040, 5'b10100, 8'h10, 3'd0, 32'hE2000040}, // R11
    {4'd11, 32'hC0000000, 5'b00100, 8'h10, 3'd1, 32'h00000000}  // R11
  };

  task automatic check(string tag, logic [2:0] e_exc, logic [31:0] e_pa);
    n_run++;
    if (!valid || exc !== e_exc || pa !== e_pa) begin
      n_fail++;
      $display("FAIL %s: valid=%0b exc=%0d pa=%h, expected valid=1 exc=%0d pa=%h",
               tag, valid, exc, pa, e_exc, e_pa);
    end
  endtask

  task automatic access(logic [31:0] a, logic [4:0] ctl, logic [7:0] id);
    @(negedge clk);
    va = a; {wr, priv, at, sv, sqmd} = ctl; asid = id; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic load_default();
    tlb = {mk(22'h008000, 8'h10, 19'h14000, 2'd2, 1, 0, 1, 1, 0),
           mk(22'h004000, 8'h55, 19'h28000, 2'd3, 1, 1, 1, 0, 1),
           mk(22'h002000, 8'h22, 19'h00400, 2'd0, 1, 0, 0, 1, 1),
           mk(22'h001000, 8'h10, 19'h30000, 2'd1, 1, 0, 1, 1, 1)};
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    load_default();
    repeat (3) @(negedge clk);
    // R12: reset state
    n_run++;
    if (valid !== 1'b0 || exc !== 3'd0 || pa !== 32'h0) begin
      n_fail++;
      $display("FAIL R12 reset: valid=%0b exc=%0d pa=%h, expected 0 0 0", valid, exc, pa);
    end
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][79:48], VEC[i][47:43], VEC[i][42:35]);
      check($sformatf("R%0d vec%0d", VEC[i][83:80], i), VEC[i][34:32], VEC[i][31:0]);
    end

    // R12: hold and no strobe while idle, inputs moving
    @(negedge clk);
    va = 32'h8C00_0000; priv = 1'b1;
    @(negedge clk);
    n_run++;
    if (valid !== 1'b0 || exc !== 3'd1 || pa !== 32'h0) begin
      n_fail++;
      $display("FAIL R12 hold: valid=%0b exc=%0d pa=%h, expected 0 1 0", valid, exc, pa);
    end

    // R6/R11: overlapping entries give multi-hit ahead of protection
    tlb[223:168] = mk(22'h002000, 8'h22, 19'h00500, 2'd0, 1, 0, 1, 1, 1);
    access(32'h00800100, 5'b00100, 8'h22);
    check("R6 R11 multi before prot", 3'd4, 32'h0);
    load_default();

    // R11: protection ahead of initial write
    tlb[167:112] = mk(22'h004000, 8'h55, 19'h28000, 2'd3, 1, 1, 1, 0, 0);
    access(32'h010BCDEF, 5'b10100, 8'h77);
    check("R11 prot before init", 3'd6, 32'h0);
    load_default();

    // R5: invalid entry never matches
    tlb[55:0] = mk(22'h001000, 8'h10, 19'h30000, 2'd1, 0, 0, 1, 1, 1);
    access(32'h00400ABC, 5'b00100, 8'h10);
    check("R5 invalid entry", 3'd2, 32'h0);
    load_default();

    // R12: back-to-back requests each strobe once
    access(32'hE0000010, 5'b01100, 8'h10);
    check("R12 b2b first", 3'd0, 32'hE0000010);
    access(32'hA0000020, 5'b01100, 8'h10);
    check("R12 b2b second", 3'd0, 32'h00000020);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule